// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a small microprogrammed processor. A fixed control store holds 34-bit microinstructions. A 6-bit microaddress register selects one of them, and the selected word is driven to the datapath as the control word for that cycle. Bits 33 down to 6 of a word are individual control lines, one line per bit. Bits 5 down to 0 name the microaddress to visit next.

One value of that next-address field is reserved: all ones. This value makes the sequencer leave the current routine. It forms the next address by putting two ones above the 4-bit opcode taken from the instruction register. Each machine instruction therefore enters its own execute routine in the region from 48 to 63. The common fetch routine starts at address 0, and every execute routine ends by naming address 0 again.

The store contents are a parameter of the block. The default is a minimal program, and a user supplies the real microprogram through the parameter. The control word is read from the store synchronously, so the store can map onto a block RAM. The word for the new microaddress is captured on the same edge that loads the microaddress register.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the microaddress becomes 0 after that edge, and the control word becomes the word stored at address 0.
- R2: After every rising edge, `ctrl_o` holds the store word at the address shown on `uaddr_o` (bits 33:6 are control lines, bits 5:0 are the next-address field).
- R3: When the next-address field of the current word is not 6'b111111, the microaddress after the next edge equals that field.
- R4: When the next-address field of the current word is 6'b111111, the microaddress after the next edge is {2'b11, opcode_i}, where `opcode_i` is the value sampled at that edge. This gives an address from 48 to 63.
- R5: The opcodes 0000 (store), 0001 (add), 0010 (subtract), 0011 (AND), 0100 (OR) and 0101 (shift left) dispatch to addresses 48, 49, 50, 51, 52 and 53.
- R6: Any microaddress from 54 to 63, whether reached by dispatch or by a direct field, presents an all-zero control word, so the following step returns to address 0.
- R7: In cycles where the next-address field is not all ones, `opcode_i` has no effect on the microaddress sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | 4 | Opcode field from the instruction register |
| ctrl_o | output | 34 | Control word at the current microaddress |
| uaddr_o | output | 6 | Current microaddress |

## Verification
The hardest case to reach is a cycle in which the opcode changes at the exact edge where a dispatch happens, or in a cycle next to a dispatch. A stale or early opcode sample would still look correct if the opcode were held steady. The stimulus therefore runs every routine first with a steady opcode. It then switches to a phase where the opcode changes on every cycle. In that phase, each dispatch takes the value present only at its own edge. The stimulus also dispatches with opcodes 0110, 0111 and 1111 into the empty region above the store, and includes a reset that arrives in the middle of a routine.

// File: rtl/usq_pkg.sv
package usq_pkg;

  localparam int CW_D    = 34;
  localparam int AW_D    = 6;
  localparam int OPW_D   = 4;
  localparam int DEPTH_D = 54;

  // Minimal default program: fetch 0 -> 1 -> 2 -> dispatch,
  // every execute entry (48..53) returns straight to 0.
  function automatic logic [CW_D*DEPTH_D-1:0] default_image();
    logic [CW_D*DEPTH_D-1:0] img;
    logic [CW_D-1:0] w;
    img = '0;
    for (int a = 0; a < DEPTH_D; a++) begin
      w = '0;
      w[AW_D + (a % (CW_D - AW_D))] = 1'b1;
      if (a == 0)      w[AW_D-1:0] = AW_D'(1);
      else if (a == 1) w[AW_D-1:0] = AW_D'(2);
      else if (a == 2) w[AW_D-1:0] = '1;
      else             w[AW_D-1:0] = '0;
      img[a*CW_D +: CW_D] = w;
    end
    return img;
  endfunction

endpackage

// File: rtl/usq_next.sv
module usq_next #(
  parameter int AW  = 6,
  parameter int OPW = 4
) (
  input  logic [AW-1:0]  field_i,
  input  logic [OPW-1:0] opcode_i,
  output logic [AW-1:0]  next_o
);
  localparam int PREFIX_W = AW - OPW;
  localparam logic [AW-1:0] JUMP_CODE = '1;

  logic [AW-1:0] entry;

  assign entry = {{PREFIX_W{1'b1}}, opcode_i};

  always_comb begin
    if (field_i == JUMP_CODE) next_o = entry;
    else                      next_o = field_i;
  end
endmodule

// File: rtl/usq_store.sv
module usq_store #(
  parameter int CW    = 34,
  parameter int AW    = 6,
  parameter int DEPTH = 54,
  parameter logic [CW*DEPTH-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr_i,
  output logic [CW-1:0] rdata_o
);
  logic [CW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = IMAGE[g*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (int'(raddr_i) < DEPTH) rdata_o <= mem[raddr_i];
    else                       rdata_o <= '0;
  end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer #(
  parameter int CW    = usq_pkg::CW_D,
  parameter int AW    = usq_pkg::AW_D,
  parameter int OPW   = usq_pkg::OPW_D,
  parameter int DEPTH = usq_pkg::DEPTH_D,
  parameter logic [CW*DEPTH-1:0] IMAGE = usq_pkg::default_image()
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode_i,
  output logic [CW-1:0]  ctrl_o,
  output logic [AW-1:0]  uaddr_o
);
  logic [AW-1:0] next_addr;
  logic [AW-1:0] read_addr;
  logic [AW-1:0] uaddr_q;

  usq_next #(.AW(AW), .OPW(OPW)) u_next (
    .field_i  (ctrl_o[AW-1:0]),
    .opcode_i (opcode_i),
    .next_o   (next_addr)
  );

  assign read_addr = rst_n ? next_addr : '0;

  usq_store #(.CW(CW), .AW(AW), .DEPTH(DEPTH), .IMAGE(IMAGE)) u_store (
    .clk     (clk),
    .raddr_i (read_addr),
    .rdata_o (ctrl_o)
  );

  always_ff @(posedge clk) uaddr_q <= read_addr;

  assign uaddr_o = uaddr_q;
endmodule

// File: rtl/usq_sequencer_chk.sv
module usq_sequencer_chk #(
  parameter int CW    = 34,
  parameter int AW    = 6,
  parameter int OPW   = 4,
  parameter int DEPTH = 54
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] opcode_i,
  input logic [CW-1:0]  ctrl_o,
  input logic [AW-1:0]  uaddr_o
);
  // R1
  reset_home_chk: assert property (@(posedge clk) !rst_n |=> uaddr_o == '0);

  // R3
  direct_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[AW-1:0] != '1) |=> uaddr_o == $past(ctrl_o[AW-1:0]));

  // R4
  dispatch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[AW-1:0] == '1) |=> uaddr_o == {{(AW-OPW){1'b1}}, $past(opcode_i)});

  // R5
  dispatch_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[AW-1:0] == '1) |=> uaddr_o[AW-1:OPW] == '1);

  // R6
  empty_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(uaddr_o) >= DEPTH) |-> ctrl_o == '0);
endmodule

bind usq_sequencer usq_sequencer_chk #(.CW(CW), .AW(AW), .OPW(OPW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .ctrl_o(ctrl_o), .uaddr_o(uaddr_o)
);

// File: tb/usq_sequencer_test.sv
module usq_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 34;
  localparam int AW = 6;
  localparam int DEPTH = 54;
  localparam int WATCHDOG = 20000;

  function automatic logic [5:0] link(input int a);
    case (a)
      0: return 6'd1;   1: return 6'd2;   2: return 6'd63;
      48: return 6'd10; 10: return 6'd0;
      49: return 6'd11; 11: return 6'd12; 12: return 6'd60;
      50: return 6'd0;
      51: return 6'd20; 20: return 6'd21; 21: return 6'd22; 22: return 6'd0;
      52: return 6'd0;
      53: return 6'd30; 30: return 6'd0;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [CW-1:0] word_at(input int a);
    logic [5:0] v;
    if (a >= DEPTH) return '0;
    v = 6'(a);
    return {v, ~v, v, ~v, v[3:0], link(a)};
  endfunction

  function automatic logic [CW*DEPTH-1:0] build_image();
    logic [CW*DEPTH-1:0] img;
    img = '0;
    for (int a = 0; a < DEPTH; a++) img[a*CW +: CW] = word_at(a);
    return img;
  endfunction

  localparam logic [CW*DEPTH-1:0] IMG = build_image();

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] opcode_i;
  logic [CW-1:0] ctrl_o;
  logic [AW-1:0] uaddr_o;

  int compared = 0;
  int mismatched = 0;
  int model_addr = 0;
  string tag = "R1";
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  usq_sequencer #(.IMAGE(IMG)) uut (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .ctrl_o(ctrl_o), .uaddr_o(uaddr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare();
    logic [CW-1:0] exp_w;
    exp_w = word_at(model_addr);
    compared++;
    if (uaddr_o !== 6'(model_addr)) begin
      mismatched++;
      $display("FAIL %s uaddr actual=%0d expected=%0d", tag, uaddr_o, model_addr);
    end
    compared++;
    if (ctrl_o !== exp_w) begin
      mismatched++;
      $display("FAIL %s ctrl actual=%h expected=%h",
               (model_addr >= DEPTH) ? "R6" : "R2", ctrl_o, exp_w);
    end
  endtask

  // One cycle: check current state, drive inputs, advance the model.
  task automatic step(input logic [3:0] op, input logic rn, input bit scrambled);
    logic [5:0] f;
    @(negedge clk);
    compare();
    opcode_i = op;
    rst_n = rn;
    f = word_at(model_addr)[5:0];
    if (!rn) begin
      model_addr = 0; tag = "R1";
    end else if (f == 6'h3F) begin
      model_addr = 48 + int'(op);
      tag = (op <= 4'd5) ? "R5" : "R4";
    end else begin
      model_addr = int'(f);
      tag = scrambled ? "R7" : "R3";
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    opcode_i = 4'd0;
    model_addr = 0;
    tag = "R1";
    @(posedge clk);
    step(4'd0, 1'b0, 0);
    step(4'd0, 1'b0, 0);
    // R5: every defined opcode held through fetch and execute
    for (int op = 0; op < 6; op++)
      for (int k = 0; k < 10; k++) step(4'(op), 1'b1, 0);
    // R6: dispatch into the empty region
    for (int k = 0; k < 6; k++) step(4'd6, 1'b1, 0);
    for (int k = 0; k < 6; k++) step(4'd7, 1'b1, 0);
    for (int k = 0; k < 6; k++) step(4'd15, 1'b1, 0);
    // R7: opcode changes every cycle
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] % 4'd8, 1'b1, 1);
    end
    // R1: reset in mid-routine, then resume
    for (int k = 0; k < 5; k++) step(4'd3, 1'b1, 0);
    step(4'd3, 1'b0, 0);
    for (int k = 0; k < 12; k++) step(4'd1, 1'b1, 0);
    @(negedge clk);
    compare();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule